// File: doc/BRIEF.md
# Cacheline-Aware Write Burst Planner

This block plans the write bursts of a bus master. A request gives a dword-aligned byte start address and a dword count. The cacheline size and an invalidate-enable bit are sampled when the request is accepted. The planner cuts the request into bursts. For each burst it presents a command, a byte address and a length on a simple burst interface. The target answers once per burst with the number of dwords it took before it disconnected.

A burst that covers only whole, aligned cachelines uses the Memory Write and Invalidate command. Every other burst uses plain Memory Write. A line that a target cut short is finished with plain Memory Write up to the next line boundary. After the full count has been accepted, the planner pulses a done flag and returns to idle.

Top module: `wr_burst_planner`

## Requirements
- R1: The invalidate command (4'b1111) is issued only when invalidation is enabled, the line size is 8 or 16 dwords, the burst address is on a line boundary, and the burst length is a non-zero multiple of the line size. In that case the length equals the remaining count rounded down to whole lines.
- R2: If a request starts off a line boundary, its first burst uses Memory Write (4'b0111) and runs up to the next boundary, or covers the whole request if that is shorter.
- R3: A trailing part shorter than one line, starting on a line boundary, is issued as one Memory Write burst.
- R4: When an invalidate burst is disconnected partway through a line, the next burst uses Memory Write and covers the rest of that line, or whatever is left of the request if less.
- R5: When a disconnect lands exactly on a line boundary, the next burst starts at that address and uses the invalidate command again if at least one whole line remains.
- R6: Every burst address has bits [1:0] equal to 2'b00, which selects linear ordering. Every burst length is non-zero, and the command is always 4'b0111 or 4'b1111.
- R7: When invalidation is disabled, or the line size is neither 8 nor 16, every burst is Memory Write and covers the whole remaining count.
- R8: A response that accepts zero dwords is a retry. The next burst repeats the same address, length and command.
- R9: In the cycle after the response that completes the request, done is high for exactly one cycle and busy is low.
- R10: A request pulse while busy has no effect on the bursts in progress. A request with a count of zero is not accepted.
- R11: The cycle after a request is accepted, busy and burst_valid are high and the first burst is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_addr | input | ADDR_W | Byte start address; bits [1:0] are ignored |
| req_dwords | input | CNT_W | Number of dwords to write |
| line_dw | input | 8 | Cacheline size in dwords |
| inv_en | input | 1 | Allows the invalidate command |
| busy | output | 1 | A request is in progress |
| burst_valid | output | 1 | A burst is presented |
| burst_cmd | output | 4 | Bus command of the burst |
| burst_addr | output | ADDR_W | Byte start address of the burst |
| burst_len | output | CNT_W | Burst length in dwords |
| resp_valid | input | 1 | Target result for the presented burst |
| resp_count | input | CNT_W | Dwords accepted; values above burst_len are clamped |
| done | output | 1 | One-cycle completion pulse |

## Verification
All results are registered, and each is due exactly one clock after the edge that causes it. The first burst appears the cycle after the request strobe. Every following burst, whether a retry or a resumption, appears the cycle after the response that gave rise to it. Done appears the cycle after the final response and is low again one cycle later. The bench drives and samples on the falling edge. It checks each burst against values its own functions compute from the address, remaining count and configuration. Each check is made exactly one falling edge after the stimulus that produced the result.

// File: rtl/wr_burst_planner.sv
module wr_burst_planner #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_dwords,
  input  logic [7:0]        line_dw,
  input  logic              inv_en,
  output logic              busy,
  output logic              burst_valid,
  output logic [3:0]        burst_cmd,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [CNT_W-1:0]  burst_len,
  input  logic              resp_valid,
  input  logic [CNT_W-1:0]  resp_count,
  output logic              done
);
  localparam int DW_W = ADDR_W - 2;
  localparam logic [3:0] CMD_MW  = 4'b0111;
  localparam logic [3:0] CMD_MWI = 4'b1111;

  logic              busy_q, done_q, cls16_q, mwi_ok_q;
  logic [DW_W-1:0]   cur_q;
  logic [CNT_W-1:0]  rem_q;

  logic [3:0]       mask, off;
  logic [CNT_W-1:0] to_bnd, whole, len, acc;
  logic             use_mwi;

  assign mask    = cls16_q ? 4'hF : 4'h7;
  assign off     = cur_q[3:0] & mask;
  assign to_bnd  = (cls16_q ? CNT_W'(16) : CNT_W'(8)) - CNT_W'(off);
  assign whole   = rem_q & ~CNT_W'(mask);
  assign use_mwi = mwi_ok_q && off == 4'd0 && whole != '0;
  assign len     = use_mwi ? whole :
                   (mwi_ok_q && off != 4'd0 && rem_q > to_bnd) ? to_bnd : rem_q;
  assign acc     = (resp_count > len) ? len : resp_count;

  assign busy        = busy_q;
  assign burst_valid = busy_q;
  assign burst_cmd   = use_mwi ? CMD_MWI : CMD_MW;
  assign burst_addr  = {cur_q, 2'b00};
  assign burst_len   = len;
  assign done        = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      cls16_q  <= 1'b0;
      mwi_ok_q <= 1'b0;
      cur_q    <= '0;
      rem_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid && req_dwords != '0) begin
          busy_q   <= 1'b1;
          cur_q    <= req_addr[ADDR_W-1:2];
          rem_q    <= req_dwords;
          cls16_q  <= (line_dw == 8'd16);
          mwi_ok_q <= inv_en && (line_dw == 8'd8 || line_dw == 8'd16);
        end
      end else if (resp_valid && acc != '0) begin
        cur_q <= cur_q + DW_W'(acc);
        rem_q <= rem_q - acc;
        if (rem_q == acc) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

module wr_burst_planner_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              burst_valid,
  input logic [3:0]        burst_cmd,
  input logic [ADDR_W-1:0] burst_addr,
  input logic [CNT_W-1:0]  burst_len,
  input logic              resp_valid,
  input logic [CNT_W-1:0]  resp_count,
  input logic              done,
  input logic              cls16_q,
  input logic              mwi_ok_q
);
  assert_mwi_whole_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && burst_cmd == 4'b1111 |-> mwi_ok_q &&
      (cls16_q ? (burst_addr[5:2] == 4'd0 && burst_len[3:0] == 4'd0)
               : (burst_addr[4:2] == 3'd0 && burst_len[2:0] == 3'd0)) && burst_len != '0);

  assert_linear_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> burst_addr[1:0] == 2'b00 && burst_len != '0 &&
      (burst_cmd == 4'b0111 || burst_cmd == 4'b1111));

  assert_disabled_plain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && !mwi_ok_q |-> burst_cmd == 4'b0111);

  assert_retry_same_R8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && resp_valid && resp_count == '0 |=>
      burst_valid && $stable(burst_addr) && $stable(burst_len) && $stable(burst_cmd));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);
endmodule

bind wr_burst_planner wr_burst_planner_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .burst_valid(burst_valid),
  .burst_cmd(burst_cmd), .burst_addr(burst_addr), .burst_len(burst_len),
  .resp_valid(resp_valid), .resp_count(resp_count), .done(done),
  .cls16_q(cls16_q), .mwi_ok_q(mwi_ok_q)
);

// File: tb/wr_burst_planner_test.sv
module wr_burst_planner_test;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, inv_en = 1'b0, resp_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CNT_W-1:0]  req_dwords = '0, resp_count = '0;
  logic [7:0]        line_dw = 8'd8;
  logic busy, burst_valid, done;
  logic [3:0] burst_cmd;
  logic [ADDR_W-1:0] burst_addr;
  logic [CNT_W-1:0]  burst_len;

  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  wr_burst_planner #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_dwords(req_dwords), .line_dw(line_dw), .inv_en(inv_en), .busy(busy),
    .burst_valid(burst_valid), .burst_cmd(burst_cmd), .burst_addr(burst_addr),
    .burst_len(burst_len), .resp_valid(resp_valid), .resp_count(resp_count), .done(done));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic bit ok_cfg(int c, bit en);
    return en && (c == 8 || c == 16);
  endfunction

  function automatic bit exp_mwi(int cur, int rem, int c, bit en);
    return ok_cfg(c, en) && (cur % c == 0) && rem >= c;
  endfunction

  function automatic int exp_len(int cur, int rem, int c, bit en);
    if (!ok_cfg(c, en)) return rem;
    if (cur % c == 0) return (rem >= c) ? rem - rem % c : rem;
    return (rem > c - cur % c) ? c - cur % c : rem;
  endfunction

  task automatic check_burst(int cur, int rem, int c, bit en, string tag);
    int  el = exp_len(cur, rem, c, en);
    bit  em = exp_mwi(cur, rem, c, en);
    check(burst_valid === 1'b1, {tag, " R11 valid"}, burst_valid, 1);
    check(burst_cmd === (em ? 4'b1111 : 4'b0111), {tag, " R6 cmd"}, burst_cmd, em ? 15 : 7);
    check(burst_addr === ADDR_W'(cur * 4), {tag, " R6 addr"}, burst_addr, cur * 4);
    check(burst_len === CNT_W'(el), {tag, " len"}, burst_len, el);
  endtask

  // cut < 0: random target policy on every burst; otherwise first burst accepts cut, rest full
  task automatic run_req(int a, int n, int c, bit en, int cut, bit poke);
    int cur = a, rem = n, guard = 0, acc, el;
    bit first = 1'b1;
    string tag;
    string why = "";
    req_valid = 1'b1; req_addr = ADDR_W'(a * 4); req_dwords = CNT_W'(n);
    line_dw = 8'(c); inv_en = en;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy === 1'b1, "R11 busy after accept", busy, 1);
    while (rem > 0 && guard < 400) begin
      guard++;
      if (!ok_cfg(c, en)) tag = "R7";
      else if (why != "") tag = why;
      else if (exp_mwi(cur, rem, c, en)) tag = "R1";
      else if (cur % c != 0) tag = "R2";
      else tag = "R3";
      check_burst(cur, rem, c, en, tag);
      el = exp_len(cur, rem, c, en);
      for (int w = $urandom_range(0, 2); w > 0; w--) begin
        if (poke) begin
          req_valid = 1'b1; req_addr = ADDR_W'($urandom_range(0, 4095) * 4);
          req_dwords = CNT_W'($urandom_range(1, 50)); line_dw = 8'd16; inv_en = 1'b1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) check_burst(cur, rem, c, en, "R10 ignored");
      end
      if (cut >= 0 && first) acc = (cut > el) ? el : cut;
      else if (cut >= 0) acc = el;
      else begin
        case ($urandom_range(0, 3))
          0: acc = 0;
          1: acc = $urandom_range(1, el);
          default: acc = el;
        endcase
      end
      first = 1'b0;
      resp_valid = 1'b1; resp_count = CNT_W'(acc);
      @(negedge clk);
      resp_valid = 1'b0;
      if (acc == 0) why = "R8";
      else if (exp_mwi(cur, rem, c, en) && acc < el)
        why = ((cur + acc) % c == 0) ? "R5" : "R4";
      else why = "";
      cur += acc; rem -= acc;
      if (rem == 0) begin
        check(done === 1'b1, "R9 done", done, 1);
        check(busy === 1'b0, "R9 busy low", busy, 0);
        @(negedge clk);
        check(done === 1'b0, "R9 single pulse", done, 0);
      end else begin
        check(done === 1'b0, "R9 no early done", done, 0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd7311));
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R9 reset busy", busy, 0);
    check(burst_valid === 1'b0, "R11 reset valid", burst_valid, 0);
    check(done === 1'b0, "R9 reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    req_valid = 1'b1; req_dwords = '0; req_addr = 32'h40;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy === 1'b0, "R10 zero count ignored", busy, 0);

    run_req(64, 32, 8, 1'b1, -1 + 1 + 32, 1'b0);  // R1 aligned whole lines
    run_req(5, 30, 8, 1'b1, 100, 1'b0);           // R2 leading part, R3 tail
    run_req(32, 40, 16, 1'b1, 5, 1'b0);           // R4 mid-line cut
    run_req(32, 40, 16, 1'b1, 16, 1'b0);          // R5 boundary cut
    run_req(16, 24, 8, 1'b1, 8, 1'b0);            // R5 with 8-dword lines
    run_req(48, 32, 16, 1'b1, 0, 1'b1);           // R8 retry, R10 pokes
    run_req(0, 64, 16, 1'b0, 100, 1'b0);          // R7 disabled
    run_req(0, 40, 12, 1'b1, 100, 1'b0);          // R7 unsupported size
    run_req(3, 2, 8, 1'b1, 100, 1'b0);            // R2 shorter than line

    for (int i = 0; i < 250; i++) begin
      int cs = $urandom_range(0, 3);
      run_req($urandom_range(0, 2047), $urandom_range(1, 90),
              (cs == 3) ? 12 : ((cs == 0) ? 8 : 16), ($urandom_range(0, 4) != 0),
              -1, ($urandom_range(0, 3) == 0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule